// File: doc/BRIEF.md
# Post-Train Ramp Digitizer Sequencer

This block digitizes the analog samples that a pixel holds in its storage slots once a bunch train has ended. It does nothing during the train. A train-end pulse arms it, and a later start pulse launches the conversion. During the conversion it raises a ramp-enable output for the external analog ramp and runs a shared counter next to it. Each storage slot freezes the counter value at the moment its comparator first trips. The comparators and the ramp are external and reach the block only as digital inputs.

After the full ramp, the block walks the slots in ascending order and sends one record for each slot that the capture logic marked as occupied. Each record carries the range (gain) flag, the bunch timestamp and the conversion code. Empty slots are skipped and cost no cycles. The records leave on a valid/ready stream. A single-cycle done pulse closes the readout, and the block then waits for the next train end.

Top module: `wk_train_digitizer`

## Requirements
- R1: While reset is held and in the first cycle after it, `ramp_run`, `out_valid` and `done` are low.
- R2: A `start` pulse has effect only after a `train_end` pulse has armed the block. A `start` in the idle state leaves `ramp_run` low.
- R3: The cycle after an accepted `start`, `ramp_run` goes high. It stays high for exactly 2^CODE_W cycles while the shared counter steps 0, 1, … 2^CODE_W−1, and then it drops.
- R4: A slot's code is the counter value in the first conversion cycle in which its comparator is high after being low. The comparator counts as low before the first conversion cycle. Later rising edges in the same conversion are ignored.
- R5: A slot whose comparator never rises during the conversion gets the all-ones code (8191 for 13 bits).
- R6: Only slots whose `slot_valid` bit is set produce a record, in ascending slot index. While `out_ready` stays high, records follow on consecutive cycles with no empty cycle between them. No record appears while `ramp_run` is high.
- R7: Record layout: bit 25 = range flag, bits 24:13 = the slot's 12-bit timestamp, bits 12:0 = the 13-bit code. Slot i's timestamp is `slot_ts[12*i+11 : 12*i]` and its range flag is `slot_range[i]`.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change.
- R9: `done` is high for exactly one cycle. It appears in the cycle after the last record is accepted, or the cycle after the ramp ends if no slot is valid. `out_valid` is low at that time, and the block is then idle and can be armed again.
- R10: `slot_valid`, `slot_ts` and `slot_range` are sampled on the clock edge that accepts `start`. Changes to them during the conversion have no effect on the records.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| train_end | input | 1 | Pulse marking the end of a bunch train; arms the block |
| start | input | 1 | Launches the conversion once the block is armed |
| slot_valid | input | NSLOT | Occupancy flag per storage slot |
| slot_ts | input | NSLOT*TS_W | Packed bunch timestamps, slot 0 in the low bits |
| slot_range | input | NSLOT | Gain-range flag per slot |
| cmp | input | NSLOT | Comparator output per slot (ramp has crossed the stored sample) |
| ramp_run | output | 1 | Enables the external ramp during conversion |
| out_valid | output | 1 | Record available |
| out_ready | input | 1 | Downstream accepts the record |
| out_data | output | TS_W+CODE_W+1 | Record: {range, timestamp, code} |
| done | output | 1 | One-cycle pulse at the end of the readout |

## Verification
The bench runs four trains with different occupancy masks. A full mask tells apart a trip in the very first ramp cycle, a trip in the last cycle and a slot that never trips; the last two must both give the all-ones code. A sparse mask where the unoccupied slots also trip, with a comparator that rises twice, shows that skipping is by occupancy and that only the first edge counts. The same train changes the slot inputs during the ramp, which shows they are captured at start. An empty mask checks that `done` still comes without a record. Periodic and alternating back-pressure shows that a stalled record is held and that order is kept.

// File: rtl/wk_pkg.sv
// Shared types for the post-train digitizer sequencer.
// Assumes: one sequencer per pixel; the slot count and widths come from the top.
package wk_pkg;
    // Sequencer phases: idle, armed after train end, ramp running, readout.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_CONV  = 2'd2,
        ST_READ  = 2'd3
    } wk_state_t;
endpackage

// File: rtl/wk_ramp_counter.sv
// Shared conversion counter that runs next to the external ramp.
// Clears on launch and steps by one per conversion cycle. Flags its final
// value so that the sequencer can end the ramp after 2^CODE_W cycles.
module wk_ramp_counter #(
    parameter int CODE_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              run,
    output logic [CODE_W-1:0] cnt,
    output logic              last
);
    // Step the counter while the ramp runs; restart it at launch.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (clear) cnt <= '0;
        else if (run)   cnt <= cnt + 1'b1;
    end

    // Final count value: the last conversion cycle.
    assign last = (cnt == {CODE_W{1'b1}});
endmodule

// File: rtl/wk_slot_capture.sv
// Per-slot code latch. Freezes the shared count on the first rising edge of
// the slot comparator during a conversion. It takes all-ones if no edge
// arrives before the final count. Assumes cmp is already synchronous.
module wk_slot_capture #(
    parameter int CODE_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              run,
    input  logic              last,
    input  logic              cmp,
    input  logic [CODE_W-1:0] cnt,
    output logic [CODE_W-1:0] code
);
    logic prev_q;
    logic hit_q;

    // Track the comparator edge and latch the count once per conversion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            hit_q  <= 1'b0;
            code   <= '0;
        end else if (arm) begin
            prev_q <= 1'b0;
            hit_q  <= 1'b0;
            code   <= '0;
        end else if (run) begin
            prev_q <= cmp;
            if (cmp && !prev_q && !hit_q) begin
                code  <= cnt;
                hit_q <= 1'b1;
            end else if (last && !hit_q) begin
                code <= {CODE_W{1'b1}};
            end
        end
    end
endmodule

// File: rtl/wk_slot_picker.sv
// Picks the lowest-index slot still pending readout and reports whether it
// is the only one left. Purely combinational.
module wk_slot_picker #(
    parameter int NSLOT = 4,
    parameter int SEL_W = 2
) (
    input  logic [NSLOT-1:0] pend,
    output logic [SEL_W-1:0] sel,
    output logic             any,
    output logic             one_left
);
    // Priority search from the top so that the lowest set bit wins.
    always_comb begin
        sel = '0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (pend[i]) sel = SEL_W'(i);
        end
    end

    assign any      = |pend;
    assign one_left = ($countones(pend) == 1);
endmodule

// File: rtl/wk_train_digitizer.sv
// Post-train single-slope digitizer sequencer for one pixel.
// It waits for train end, then for start. It runs the ramp for 2^CODE_W
// cycles while each slot captures its code. Then it streams one record per
// occupied slot in slot order, and pulses done at the end.
// Assumes comparator inputs are synchronous to clk and slot inputs are
// steady on the start edge.
module wk_train_digitizer
    import wk_pkg::*;
#(
    parameter int NSLOT  = 4,
    parameter int TS_W   = 12,
    parameter int CODE_W = 13
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   train_end,
    input  logic                   start,
    input  logic [NSLOT-1:0]       slot_valid,
    input  logic [NSLOT*TS_W-1:0]  slot_ts,
    input  logic [NSLOT-1:0]       slot_range,
    input  logic [NSLOT-1:0]       cmp,
    output logic                   ramp_run,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [TS_W+CODE_W:0]   out_data,
    output logic                   done
);
    localparam int SEL_W = (NSLOT > 1) ? $clog2(NSLOT) : 1;

    wk_state_t         state_q;
    logic [NSLOT-1:0]  pend_q;
    logic [TS_W-1:0]   snap_ts  [NSLOT];
    logic [NSLOT-1:0]  snap_rng;
    logic [CODE_W-1:0] cnt;
    logic              cnt_last;
    logic [CODE_W-1:0] code [NSLOT];
    logic [SEL_W-1:0]  sel;
    logic              any_pend;
    logic              one_left;
    logic              launch;
    logic              run;
    logic              accept;

    assign launch = (state_q == ST_ARMED) && start;
    assign run    = (state_q == ST_CONV);

    wk_ramp_counter #(.CODE_W(CODE_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (launch),
        .run   (run),
        .cnt   (cnt),
        .last  (cnt_last)
    );

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        wk_slot_capture #(.CODE_W(CODE_W)) u_cap (
            .clk   (clk),
            .rst_n (rst_n),
            .arm   (launch),
            .run   (run),
            .last  (cnt_last),
            .cmp   (cmp[g]),
            .cnt   (cnt),
            .code  (code[g])
        );
    end

    wk_slot_picker #(.NSLOT(NSLOT), .SEL_W(SEL_W)) u_pick (
        .pend     (pend_q),
        .sel      (sel),
        .any      (any_pend),
        .one_left (one_left)
    );

    // Snapshot slot timestamps and range flags at launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_rng <= '0;
            for (int i = 0; i < NSLOT; i++) snap_ts[i] <= '0;
        end else if (launch) begin
            snap_rng <= slot_range;
            for (int i = 0; i < NSLOT; i++) snap_ts[i] <= slot_ts[i*TS_W +: TS_W];
        end
    end

    // Phase sequencing, pending-slot bookkeeping and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pend_q  <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state_q)
                ST_IDLE:  if (train_end) state_q <= ST_ARMED;
                ST_ARMED: if (start) begin
                    state_q <= ST_CONV;
                    pend_q  <= slot_valid;
                end
                ST_CONV:  if (cnt_last) begin
                    if (pend_q == '0) begin
                        done    <= 1'b1;
                        state_q <= ST_IDLE;
                    end else begin
                        state_q <= ST_READ;
                    end
                end
                ST_READ:  if (accept) begin
                    pend_q[sel] <= 1'b0;
                    if (one_left) begin
                        done    <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // Output stream: the selected slot's record, held until accepted.
    assign ramp_run  = run;
    assign out_valid = (state_q == ST_READ) && any_pend;
    assign accept    = out_valid && out_ready;
    assign out_data  = {snap_rng[sel], snap_ts[sel], code[sel]};
endmodule

// File: rtl/wk_digitizer_chk.sv
// Protocol and timing checker for wk_train_digitizer, attached by bind.
// Watches the ports and the shared conversion counter.
module wk_digitizer_chk #(
    parameter int CODE_W = 13,
    parameter int REC_W  = 26
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ramp_run,
    input logic              out_valid,
    input logic              out_ready,
    input logic [REC_W-1:0]  out_data,
    input logic              done,
    input logic [CODE_W-1:0] cnt
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!ramp_run && !out_valid && !done)); // R1

    AST_RAMP_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ramp_run) |-> (cnt == '0)); // R3

    AST_RAMP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp_run && $past(ramp_run)) |-> (cnt == CODE_W'($past(cnt) + 1'b1))); // R3

    AST_NO_RECORD_IN_RAMP: assert property (@(posedge clk) disable iff (!rst_n)
        !(ramp_run && out_valid)); // R6

    AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_DONE_NO_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !out_valid); // R9
endmodule

bind wk_train_digitizer wk_digitizer_chk #(
    .CODE_W (CODE_W),
    .REC_W  (TS_W + CODE_W + 1)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ramp_run  (ramp_run),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .done      (done),
    .cnt       (cnt)
);

// File: tb/sim_wk_train_digitizer.sv
// Self-checking bench: a behavioural model predicts ramp, records and done
// on every cycle. Inputs are driven and outputs sampled at the falling edge.
module sim_wk_train_digitizer;
    localparam int NSLOT  = 4;
    localparam int TS_W   = 12;
    localparam int CODE_W = 13;
    localparam int REC_W  = TS_W + CODE_W + 1;
    localparam int NCONV  = 1 << CODE_W;
    localparam int MAXC   = NCONV - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic train_end = 1'b0;
    logic start = 1'b0;
    logic out_ready = 1'b0;
    logic [NSLOT-1:0] slot_valid = '0;
    logic [NSLOT-1:0] slot_range = '0;
    logic [NSLOT-1:0] cmp = '0;
    logic [NSLOT*TS_W-1:0] slot_ts = '0;
    logic ramp_run, out_valid, done;
    logic [REC_W-1:0] out_data;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;
    int a1 [NSLOT];
    int a2 [NSLOT];
    logic [REC_W-1:0] expq [$];

    always #4 clk = ~clk;

    wk_train_digitizer #(.NSLOT(NSLOT), .TS_W(TS_W), .CODE_W(CODE_W)) u0 (
        .clk(clk), .rst_n(rst_n), .train_end(train_end), .start(start),
        .slot_valid(slot_valid), .slot_ts(slot_ts), .slot_range(slot_range),
        .cmp(cmp), .ramp_run(ramp_run), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .done(done)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Runs one train: arm, launch, ramp with modelled comparators, readout.
    task automatic run_train(input logic [NSLOT-1:0] vmask,
                             input logic [NSLOT-1:0] rmask,
                             input logic [NSLOT*TS_W-1:0] ts,
                             input int stall, input bit scramble);
        int cyc;
        bit rdy;
        @(negedge clk);
        slot_valid = vmask; slot_range = rmask; slot_ts = ts; train_end = 1'b1;
        @(negedge clk);
        train_end = 1'b0;
        chk("R2", "ramp idle while armed", 32'(ramp_run), 32'd0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        expq.delete();
        for (int i = 0; i < NSLOT; i++) begin
            if (vmask[i]) begin
                int c;
                c = (a1[i] >= 0) ? a1[i] : ((a2[i] >= 0) ? a2[i] : MAXC);
                expq.push_back({rmask[i], ts[i*TS_W +: TS_W], CODE_W'(c)});
            end
        end
        for (int k = 0; k < NCONV; k++) begin
            chk("R3", "ramp high during conversion", 32'(ramp_run), 32'd1);
            chk("R6", "no record during ramp", 32'(out_valid), 32'd0);
            for (int i = 0; i < NSLOT; i++)
                cmp[i] = (a1[i] >= 0 && k >= a1[i] && k < a1[i] + 2) ||
                         (a2[i] >= 0 && k >= a2[i]);
            if (scramble && k == 5) begin
                slot_valid = ~vmask; slot_range = ~rmask; slot_ts = ~ts;
            end
            @(negedge clk);
        end
        cmp = '0;
        chk("R3", "ramp ends after full count", 32'(ramp_run), 32'd0);
        cyc = 0;
        while (cyc < 200) begin
            if (expq.size() == 0) begin
                chk("R9", "done after readout", 32'(done), 32'd1);
                chk("R9", "no record with done", 32'(out_valid), 32'd0);
                out_ready = 1'b0;
                @(negedge clk);
                chk("R9", "done is one cycle", 32'(done), 32'd0);
                chk("R6", "no extra record", 32'(out_valid), 32'd0);
                break;
            end
            chk("R9", "no early done", 32'(done), 32'd0);
            chk("R6", "record present", 32'(out_valid), 32'd1);
            chk("R7", "record content (R4/R5/R10)", 32'(out_data), 32'(expq[0]));
            rdy = (stall == 0) ? 1'b1 : ((cyc % stall) != 0);
            out_ready = rdy;
            cyc++;
            @(negedge clk);
            if (rdy) void'(expq.pop_front());
        end
        out_ready = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "ramp in reset", 32'(ramp_run), 32'd0);
        chk("R1", "valid in reset", 32'(out_valid), 32'd0);
        chk("R1", "done in reset", 32'(done), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "valid after reset", 32'(out_valid), 32'd0);
        // R2: start without train end has no effect
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2", "start ignored when idle", 32'(ramp_run), 32'd0);
        @(negedge clk);
        chk("R2", "still idle", 32'(ramp_run), 32'd0);

        // Train 1: all slots; trip at 10, at 0, at final count, never (R5)
        a1[0] = 10;   a2[0] = -1;
        a1[1] = 0;    a2[1] = -1;
        a1[2] = MAXC; a2[2] = -1;
        a1[3] = -1;   a2[3] = -1;
        run_train(4'b1111, 4'b1010, {12'h0a3, 12'h5c1, 12'hfff, 12'h001}, 0, 1'b0);

        // R2 again: after done, start alone is ignored
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk("R2", "start ignored after done", 32'(ramp_run), 32'd0);

        // Train 2: sparse mask, double edge on slot 0 (R4), inputs scrambled (R10)
        a1[0] = 100;  a2[0] = 500;
        a1[1] = 200;  a2[1] = -1;
        a1[2] = -1;   a2[2] = 4000;
        a1[3] = 300;  a2[3] = -1;
        run_train(4'b0101, 4'b0001, {12'h111, 12'h222, 12'h333, 12'h444}, 3, 1'b1);

        // Train 3: nothing occupied, done only (R9)
        run_train(4'b0000, 4'b0000, '0, 0, 1'b0);

        // Train 4: single top slot with alternating back-pressure (R8)
        a1[0] = 50;   a2[0] = -1;
        a1[1] = -1;   a2[1] = -1;
        a1[2] = -1;   a2[2] = -1;
        a1[3] = 7000; a2[3] = -1;
        run_train(4'b1000, 4'b1000, {12'h9ab, 12'h000, 12'h000, 12'h000}, 2, 1'b0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule